// File: doc/BRIEF.md
# Serial Command Decoder with Port Registers

This block sits behind a byte-wide serial front end in a system controller that owns two 8-bit general-purpose ports. A frame opens when `frame_act` rises and closes when it falls. The first byte of a frame is an opcode. Every byte after it is counted. The block checks the opcode against a fixed table of legal codes. At the close of the frame it either applies the command or rejects it as a whole. A rejected command leaves every register as it was and puts the opcode in a failed-command register.

Reads return one response byte for each byte the host sends after the opcode, in the style of a full-duplex link. Writes are held in a staging buffer and reach the registers only at the close of a correct frame. A write also needs the write enable latch to be set. A write that is applied normally raises `wc_req` for one cycle, which asks for a nonvolatile write cycle, and clears the latch. The nonvolatile array is not part of this block.

Both byte streams use valid/ready. An input byte is taken only when `in_valid`, `in_ready` and `frame_act` are all high. `in_ready` stays low while a response byte waits on `out_ready`. A response byte keeps its value until `out_ready` accepts it, so a stalled reader never loses a byte and never sees two bytes overlap.

Top module: `serial_cmd_ctrl`

## Requirements
- R1: Only these opcodes are legal: 00, 03, 0C, 05, 06, 09, 0A, 51, 91, 52, 92, 54, 94, 58, 98, 5C, 9C, DE, D3, D5, D0, 62, A2, 64, A4, 68, A8, E3, E5, E0, DF, EF (hex). When a frame with any other opcode closes, the opcode is stored in the failed-command register and no other register changes.
- R2: A single-register read is a 3-byte frame. The response to byte 2 (bytes counted from 0, the opcode being byte 0) is the selected register, and the response to byte 1 is 00. Selection: 52/92 desired value A/B, 54/94 direction A/B, 58/98 interrupt mask A/B, D3 interrupt configuration, D5 port configuration, D0 threshold/lock, 5C/9C interrupt error inputs A/B, DE failed-command register.
- R3: A single-register write is a 3-byte frame. Byte 1 is ignored and byte 2 is the value. The targets are 62/A2 desired value A/B, 64/A4 direction A/B, 68/A8 mask A/B, E3 interrupt configuration, E5 port configuration and E0 threshold/lock. The desired value and direction registers drive `pa_drv`, `pb_drv`, `pa_dir` and `pb_dir`.
- R4: Opcode 03 sets the write enable latch and opcode 0C clears it. Each must be exactly 2 bytes long.
- R5: A write opcode (memory, single-register or multi-register) whose frame closes while the latch is clear is rejected: the opcode is recorded and nothing is written.
- R6: A frame whose byte count breaks its opcode's rule is rejected, and the opcode is recorded. The rules are: no-op at least 2 bytes, latch commands exactly 2, memory commands at least 4, single-register commands exactly 3, DF exactly 16, EF exactly 11.
- R7: DF returns 00 for byte 1. Bytes 2 to 15 then return, in this order: pins A, pins B, desired value A, desired value B, direction A, direction B, mask A, mask B, interrupt configuration, port configuration, threshold/lock, error A, error B, failed command.
- R8: EF writes bytes 2 to 10 into desired value A, desired value B, direction A, direction B, mask A, mask B, interrupt configuration, port configuration and threshold/lock, in that order.
- R9: A write that is applied (09/0A with at least 4 bytes, a single-register write, or EF) raises `wc_req` for exactly one cycle, in the cycle after the frame closes, and clears the write enable latch. Memory reads (05/06) return 00 bytes.
- R10: When bit 7 of the port configuration register is 1 (handshake mode), 62 and A2 still update their register but raise no `wc_req` and leave the latch set.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low.
- R12: After reset, all registers, the latch and the failed-command register are 0, `out_valid` and `wc_req` are low, and `in_ready` is high.
- R13: Reads 51 and 91 return the level of `pa_pins` or `pb_pins` in the cycle in which the third byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_act | input | 1 | High while a frame is open |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | A response byte is waiting |
| out_ready | input | 1 | Reader takes the response byte |
| out_data | output | 8 | Response byte |
| pa_pins | input | 8 | Pin levels of port A |
| pb_pins | input | 8 | Pin levels of port B |
| irq_err_a | input | 8 | Interrupt error flags of port A |
| irq_err_b | input | 8 | Interrupt error flags of port B |
| pa_drv | output | 8 | Desired value of port A |
| pa_dir | output | 8 | Direction of port A |
| pb_drv | output | 8 | Desired value of port B |
| pb_dir | output | 8 | Direction of port B |
| wc_req | output | 1 | One-cycle request for a nonvolatile write cycle |

## Verification
The checker watches, on every cycle, that a stalled response byte holds its value and that input is stalled while it waits. It also checks that `wc_req` lasts a single cycle, comes only just after a frame closes and always leaves the latch clear, and that the failed-command and threshold registers change only when a frame closes. Which opcode is rejected for which byte count, the order of the multi-register paths, and the way handshake mode exempts only the desired-value writes can only be seen through the bench's frames. The bench sweeps every opcode in a fixed 3-byte frame and walks each writable register with several patterns.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int DW     = 8;
  localparam int NWREG  = 9;
  localparam int NEXTRA = 5;
  localparam int NSRC   = NWREG + NEXTRA;
  localparam int SELW   = $clog2(NSRC);
  localparam int CNT_W  = 5;
  localparam int PCR_IDX = 7;
  localparam int HS_BIT  = DW - 1;

  typedef enum logic [3:0] {
    K_ILL, K_NOP, K_WSET, K_WCLR, K_MRD, K_MWR, K_RD1, K_WR1, K_RDN, K_WRN
  } kind_e;

  typedef struct packed {
    kind_e          kind;
    logic [SELW-1:0] sel;
    logic           hs_skip;
  } dec_t;

  function automatic dec_t decode(input logic [7:0] op);
    dec_t d;
    d.kind = K_ILL;
    d.sel = '0;
    d.hs_skip = 1'b0;
    case (op)
      8'h00: d.kind = K_NOP;
      8'h03: d.kind = K_WSET;
      8'h0C: d.kind = K_WCLR;
      8'h05, 8'h06: d.kind = K_MRD;
      8'h09, 8'h0A: d.kind = K_MWR;
      8'hDF: d.kind = K_RDN;
      8'hEF: d.kind = K_WRN;
      8'h51: begin d.kind = K_RD1; d.sel = SELW'(0);  end
      8'h91: begin d.kind = K_RD1; d.sel = SELW'(1);  end
      8'h52: begin d.kind = K_RD1; d.sel = SELW'(2);  end
      8'h92: begin d.kind = K_RD1; d.sel = SELW'(3);  end
      8'h54: begin d.kind = K_RD1; d.sel = SELW'(4);  end
      8'h94: begin d.kind = K_RD1; d.sel = SELW'(5);  end
      8'h58: begin d.kind = K_RD1; d.sel = SELW'(6);  end
      8'h98: begin d.kind = K_RD1; d.sel = SELW'(7);  end
      8'hD3: begin d.kind = K_RD1; d.sel = SELW'(8);  end
      8'hD5: begin d.kind = K_RD1; d.sel = SELW'(9);  end
      8'hD0: begin d.kind = K_RD1; d.sel = SELW'(10); end
      8'h5C: begin d.kind = K_RD1; d.sel = SELW'(11); end
      8'h9C: begin d.kind = K_RD1; d.sel = SELW'(12); end
      8'hDE: begin d.kind = K_RD1; d.sel = SELW'(13); end
      8'h62: begin d.kind = K_WR1; d.sel = SELW'(0); d.hs_skip = 1'b1; end
      8'hA2: begin d.kind = K_WR1; d.sel = SELW'(1); d.hs_skip = 1'b1; end
      8'h64: begin d.kind = K_WR1; d.sel = SELW'(2); end
      8'hA4: begin d.kind = K_WR1; d.sel = SELW'(3); end
      8'h68: begin d.kind = K_WR1; d.sel = SELW'(4); end
      8'hA8: begin d.kind = K_WR1; d.sel = SELW'(5); end
      8'hE3: begin d.kind = K_WR1; d.sel = SELW'(6); end
      8'hE5: begin d.kind = K_WR1; d.sel = SELW'(7); end
      8'hE0: begin d.kind = K_WR1; d.sel = SELW'(8); end
      default: d.kind = K_ILL;
    endcase
    return d;
  endfunction

  function automatic logic len_ok(input kind_e k, input logic [CNT_W-1:0] n);
    case (k)
      K_NOP:         return n >= CNT_W'(2);
      K_WSET, K_WCLR: return n == CNT_W'(2);
      K_MRD, K_MWR:  return n >= CNT_W'(4);
      K_RD1, K_WR1:  return n == CNT_W'(3);
      K_RDN:         return n == CNT_W'(NSRC + 2);
      K_WRN:         return n == CNT_W'(NWREG + 2);
      default:       return 1'b0;
    endcase
  endfunction

  function automatic logic is_wr(input kind_e k);
    return (k == K_MWR) || (k == K_WR1) || (k == K_WRN);
  endfunction

  function automatic logic is_rd(input kind_e k);
    return (k == K_MRD) || (k == K_RD1) || (k == K_RDN);
  endfunction
endpackage

// File: rtl/scc_opdecode.sv
module scc_opdecode
  import scc_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] op,
  output dec_t         dec
);
  always_comb dec = decode(op[7:0]);
endmodule

// File: rtl/scc_frame.sv
module scc_frame
  import scc_pkg::*;
#(
  parameter int W  = DW,
  parameter int NW = NWREG,
  parameter int CW = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_act,
  input  logic               fire,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       op_q,
  output logic [CW-1:0]      cnt_q,
  output logic [NW-1:0][W-1:0] stage,
  output logic               end_pulse
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic act_q;
  logic [CW-1:0] off;

  assign end_pulse = act_q && !frame_act;
  assign off = cnt_q - CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      op_q  <= '0;
    end else begin
      act_q <= frame_act;
      if (!frame_act) begin
        cnt_q <= '0;
      end else if (fire) begin
        if (cnt_q == '0) op_q <= din;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else if (fire && cnt_q >= CW'(2) && off == CW'(g)) stage[g] <= din;
    end
  end
endmodule

// File: rtl/scc_regs.sv
module scc_regs
  import scc_pkg::*;
#(
  parameter int W  = DW,
  parameter int NW = NWREG,
  parameter int CW = CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 end_pulse,
  input  dec_t                 dec,
  input  logic [W-1:0]         op_q,
  input  logic [CW-1:0]        cnt_q,
  input  logic [NW-1:0][W-1:0] stage,
  output logic [NW-1:0][W-1:0] regs,
  output logic                 wel,
  output logic [W-1:0]         fcr,
  output logic                 wc_req
);
  logic closing, bad, commit, wr, hs, start_wc;

  assign closing  = end_pulse && (cnt_q != '0);
  assign wr       = is_wr(dec.kind);
  assign bad      = (dec.kind == K_ILL) || !len_ok(dec.kind, cnt_q) || (wr && !wel);
  assign commit   = closing && !bad;
  assign hs       = regs[PCR_IDX][HS_BIT];
  assign start_wc = commit && wr && !(hs && dec.hs_skip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      fcr    <= '0;
      wc_req <= 1'b0;
    end else begin
      wc_req <= start_wc;
      if (closing && bad) fcr <= op_q;
      if (start_wc) wel <= 1'b0;
      else if (commit && dec.kind == K_WSET) wel <= 1'b1;
      else if (commit && dec.kind == K_WCLR) wel <= 1'b0;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_reg
    logic we;
    logic [W-1:0] wd;
    assign we = commit && ((dec.kind == K_WRN) ||
                           (dec.kind == K_WR1 && dec.sel == SELW'(g)));
    assign wd = (dec.kind == K_WRN) ? stage[g] : stage[0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (we) regs[g] <= wd;
    end
  end
endmodule

// File: rtl/scc_readmux.sv
module scc_readmux
  import scc_pkg::*;
#(
  parameter int W  = DW,
  parameter int NS = NSRC,
  parameter int CW = CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [CW-1:0]        idx,
  input  dec_t                 dec,
  input  logic [NS-1:0][W-1:0] src,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [W-1:0]         out_data
);
  logic            emit;
  logic [W-1:0]    nxt;
  logic [CW-1:0]   off;
  logic [SELW-1:0] pos;

  assign off = idx - CW'(2);
  assign pos = off[SELW-1:0];

  always_comb begin
    emit = fire && (idx != '0) && is_rd(dec.kind);
    nxt  = '0;
    if (dec.kind == K_RD1) begin
      if (idx == CW'(2)) nxt = src[dec.sel];
    end else if (dec.kind == K_RDN) begin
      if (idx >= CW'(2) && off < CW'(NS)) nxt = src[pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_cmd_ctrl.sv
module serial_cmd_ctrl
  import scc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_act,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [DW-1:0] pa_pins,
  input  logic [DW-1:0] pb_pins,
  input  logic [DW-1:0] irq_err_a,
  input  logic [DW-1:0] irq_err_b,
  output logic [DW-1:0] pa_drv,
  output logic [DW-1:0] pa_dir,
  output logic [DW-1:0] pb_drv,
  output logic [DW-1:0] pb_dir,
  output logic          wc_req
);
  logic                     fire, end_pulse, wel_w;
  logic [DW-1:0]            op_q, fcr_w;
  logic [CNT_W-1:0]         cnt_q;
  logic [NWREG-1:0][DW-1:0] stage, regs_w;
  logic [NSRC-1:0][DW-1:0]  src;
  dec_t                     dec;

  assign in_ready = !out_valid;
  assign fire     = in_valid && in_ready && frame_act;

  scc_frame #(.W(DW), .NW(NWREG), .CW(CNT_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .fire(fire), .din(in_data),
    .op_q(op_q), .cnt_q(cnt_q), .stage(stage), .end_pulse(end_pulse)
  );

  scc_opdecode #(.W(DW)) dec_i (.op(op_q), .dec(dec));

  scc_regs #(.W(DW), .NW(NWREG), .CW(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .dec(dec), .op_q(op_q),
    .cnt_q(cnt_q), .stage(stage), .regs(regs_w), .wel(wel_w), .fcr(fcr_w),
    .wc_req(wc_req)
  );

  assign src[0] = pa_pins;
  assign src[1] = pb_pins;
  for (genvar g = 0; g < NWREG; g++) begin : g_src
    assign src[2+g] = regs_w[g];
  end
  assign src[NWREG+2] = irq_err_a;
  assign src[NWREG+3] = irq_err_b;
  assign src[NWREG+4] = fcr_w;

  scc_readmux #(.W(DW), .NS(NSRC), .CW(CNT_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(cnt_q), .dec(dec), .src(src),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  assign pa_drv = regs_w[0];
  assign pb_drv = regs_w[1];
  assign pa_dir = regs_w[2];
  assign pb_dir = regs_w[3];
endmodule

// File: rtl/scc_chk.sv
module scc_chk
  import scc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          frame_act,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          wc_req,
  input logic          wel,
  input logic [DW-1:0] fcr,
  input logic [DW-1:0] tbl
);
  // R11
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R11
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_act) && !in_ready);
  // R9
  wc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc_req |=> !wc_req);
  // R9
  wc_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc_req |-> !$past(frame_act) && $past(frame_act, 2));
  // R9
  wc_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc_req |-> !wel);
  // R1
  fcr_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fcr) |-> !$past(frame_act) && $past(frame_act, 2));
  // R3
  tbl_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tbl) |-> !$past(frame_act) && $past(frame_act, 2));
endmodule

bind serial_cmd_ctrl scc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .wc_req(wc_req), .wel(wel_w), .fcr(fcr_w), .tbl(regs_w[8])
);

// File: tb/serial_cmd_ctrl_tb_top.sv
module serial_cmd_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, frame_act, in_valid, in_ready, out_valid, out_ready, wc_req;
  logic [7:0] in_data, out_data, pa_pins, pb_pins, irq_err_a, irq_err_b;
  logic [7:0] pa_drv, pa_dir, pb_drv, pb_dir;

  serial_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .pa_pins(pa_pins),
    .pb_pins(pb_pins), .irq_err_a(irq_err_a), .irq_err_b(irq_err_b),
    .pa_drv(pa_drv), .pa_dir(pa_dir), .pb_drv(pb_drv), .pb_dir(pb_dir),
    .wc_req(wc_req)
  );

  int vec = 0, bad = 0, rn = 0, wc_cnt = 0;
  logic [7:0] fb [0:19];
  logic [7:0] rsp [0:19];
  logic [7:0] fcr_exp = 8'h00;
  logic [7:0] wops [0:8] = '{8'h62, 8'hA2, 8'h64, 8'hA4, 8'h68, 8'hA8, 8'hE3, 8'hE5, 8'hE0};
  logic [7:0] rops [0:8] = '{8'h52, 8'h92, 8'h54, 8'h94, 8'h58, 8'h98, 8'hD3, 8'hD5, 8'hD0};
  logic [7:0] pats [0:3] = '{8'hA5, 8'h5A, 8'h7F, 8'h01};
  logic [7:0] shadow [0:8];

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (rn < 20) rsp[rn] = out_data;
      rn = rn + 1;
    end
    if (wc_req) wc_cnt = wc_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame(input int n);
    @(negedge clk);
    frame_act = 1'b1;
    rn = 0;
    for (int i = 0; i < n; i++) xfer(fb[i]);
    frame_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd1(input logic [7:0] op, output logic [7:0] v);
    fb[0] = op; fb[1] = 8'h00; fb[2] = 8'h00;
    frame(3);
    v = rsp[1];
  endtask

  task automatic wr1(input logic [7:0] op, input logic [7:0] v);
    fb[0] = op; fb[1] = 8'h00; fb[2] = v;
    frame(3);
  endtask

  task automatic wel_on();
    fb[0] = 8'h03; fb[1] = 8'h00;
    frame(2);
  endtask

  function automatic bit ok3(input logic [7:0] op);
    case (op)
      8'h00, 8'h51, 8'h91, 8'h52, 8'h92, 8'h54, 8'h94, 8'h58, 8'h98,
      8'h5C, 8'h9C, 8'hDE, 8'hD3, 8'hD5, 8'hD0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0;
    rst_n = 1'b0; frame_act = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    out_ready = 1'b1; pa_pins = 8'h3C; pb_pins = 8'hC3;
    irq_err_a = 8'h11; irq_err_b = 8'h22;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 ports", {pa_drv, pa_dir, pb_drv, pb_dir}, 32'h0);
    chk("R12 flags", {in_ready, out_valid, wc_req}, 3'b100);
    rd1(8'hDE, v); chk("R12 fcr", v, 8'h00);
    rd1(8'hD0, v); chk("R12 tbl", v, 8'h00);

    // R13 pin reads
    pa_pins = 8'h5A;
    rd1(8'h51, v); chk("R13 pins A", v, 8'h5A);
    pb_pins = 8'h96;
    rd1(8'h91, v); chk("R13 pins B", v, 8'h96);
    rd1(8'h5C, v); chk("R2 err A", v, 8'h11);
    rd1(8'h9C, v); chk("R2 err B", v, 8'h22);

    // R1 / R5 / R6: every opcode as a 3-byte frame with the latch clear
    for (int op = 0; op < 256; op++) begin
      w0 = wc_cnt;
      fb[0] = op[7:0]; fb[1] = 8'h00; fb[2] = 8'h3C;
      frame(3);
      if (!ok3(op[7:0])) fcr_exp = op[7:0];
      rd1(8'hDE, v);
      chk("R1 fcr sweep", {op[7:0], v}, {op[7:0], fcr_exp});
      chk("R5 no write", {wc_cnt[7:0], pa_drv, pb_drv, pa_dir, pb_dir}, {w0[7:0], 32'h0});
    end

    // R3 / R9 / R5 single-register writes
    for (int r = 0; r < 9; r++) begin
      for (int p = 0; p < 4; p++) begin
        wel_on();
        w0 = wc_cnt;
        wr1(wops[r], pats[p]);
        chk("R9 wc on write", wc_cnt, w0 + 1);
        rd1(rops[r], v);
        chk("R3 readback", {wops[r], v}, {wops[r], pats[p]});
        wr1(wops[r], ~pats[p]);
        fcr_exp = wops[r];
        rd1(rops[r], v);
        chk("R5 latch cleared", {wops[r], v}, {wops[r], pats[p]});
        rd1(8'hDE, v);
        chk("R5 fcr", v, fcr_exp);
        shadow[r] = pats[p];
      end
    end
    chk("R3 port outs", {pa_drv, pb_drv, pa_dir, pb_dir}, {shadow[0], shadow[1], shadow[2], shadow[3]});

    // R4 latch commands need exactly 2 bytes
    fb[0] = 8'h03; fb[1] = 8'h00; fb[2] = 8'h00;
    frame(3);
    rd1(8'hDE, v); chk("R4 set len", v, 8'h03);
    wr1(8'h62, 8'h44);
    chk("R4 set rejected", pa_drv, shadow[0]);
    wel_on();
    fb[0] = 8'h0C; fb[1] = 8'h00;
    frame(2);
    wr1(8'h62, 8'h44);
    chk("R4 clear", pa_drv, shadow[0]);
    rd1(8'hDE, v); chk("R4 fcr", v, 8'h62);

    // R6 wrong lengths
    fb[0] = 8'h00;
    frame(1);
    rd1(8'hDE, v); chk("R6 nop short", v, 8'h00);
    fb[0] = 8'h52; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
    frame(4);
    rd1(8'hDE, v); chk("R6 read long", v, 8'h52);
    fcr_exp = 8'h52;

    // R8 multi write then R7 multi read
    wel_on();
    w0 = wc_cnt;
    fb[0] = 8'hEF; fb[1] = 8'h00;
    for (int i = 0; i < 9; i++) begin
      shadow[i] = 8'h10 + 8'(i * 17);
      fb[2+i] = shadow[i];
    end
    frame(11);
    chk("R8 wc", wc_cnt, w0 + 1);
    chk("R8 ports", {pa_drv, pb_drv, pa_dir, pb_dir}, {shadow[0], shadow[1], shadow[2], shadow[3]});
    fb[0] = 8'hDF;
    for (int i = 1; i < 16; i++) fb[i] = 8'h00;
    frame(16);
    chk("R7 count", rn, 15);
    chk("R7 first", rsp[0], 8'h00);
    chk("R7 pins", {rsp[1], rsp[2]}, {pa_pins, pb_pins});
    for (int i = 0; i < 9; i++) chk("R7 regs", {8'(i), rsp[3+i]}, {8'(i), shadow[i]});
    chk("R7 tail", {rsp[12], rsp[13], rsp[14]}, {irq_err_a, irq_err_b, fcr_exp});

    // R9 memory commands
    wel_on();
    w0 = wc_cnt;
    fb[0] = 8'h09; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00; fb[4] = 8'hAA; fb[5] = 8'hBB;
    frame(6);
    chk("R9 page write", wc_cnt, w0 + 1);
    wel_on();
    w0 = wc_cnt;
    fb[0] = 8'h0A;
    frame(3);
    chk("R9 short mem write", wc_cnt, w0);
    rd1(8'hDE, v); chk("R9 mem fcr", v, 8'h0A);
    fb[0] = 8'h05; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
    frame(4);
    chk("R9 mem read", {rn[7:0], rsp[0], rsp[1], rsp[2]}, {8'd3, 24'h0});
    rd1(8'hDE, v); chk("R9 mem read ok", v, 8'h0A);

    // R10 handshake mode
    wel_on();
    wr1(8'hE5, 8'h80);
    wel_on();
    w0 = wc_cnt;
    wr1(8'h62, 8'h77);
    chk("R10 no wc", wc_cnt, w0);
    chk("R10 value", pa_drv, 8'h77);
    wr1(8'hA2, 8'h12);
    chk("R10 latch kept", {pb_drv, wc_cnt[7:0]}, {8'h12, w0[7:0]});
    wr1(8'h64, 8'h0F);
    chk("R10 other write", {pa_dir, wc_cnt[7:0]}, {8'h0F, 8'(w0 + 1)});

    // R11 back-pressure
    @(negedge clk);
    frame_act = 1'b1; rn = 0;
    xfer(8'h52);
    xfer(8'h00);
    @(negedge clk);
    out_ready = 1'b0;
    xfer(8'h00);
    v = out_data;
    chk("R11 pending", {out_valid, in_ready, v}, {1'b1, 1'b0, 8'h77});
    repeat (4) @(negedge clk);
    chk("R11 held", {out_valid, in_ready, out_data}, {1'b1, 1'b0, v});
    out_ready = 1'b1;
    @(negedge clk);
    frame_act = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 released", {out_valid, in_ready, rsp[1]}, {1'b0, 1'b1, 8'h77});

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule